// File: doc/BRIEF.md
# Signal-Processor Host Memory Window Bridge

This block gives a slave signal processor word access to three windows of a host processor's memory through two I/O ports. The processor first loads a 16-bit window pointer through the pointer port. It then reads or writes 16-bit data words through the data port, and the bridge turns each data access into one word cycle on the host bus. The pointer's top three bits select a 64 KiB host segment and its low thirteen bits select a word inside it.

Only three segments may be reached. A data access that points anywhere else never reaches the host bus: a read returns zero and a write is discarded, and in both cases a sticky error flag records it. Writing the value zero to either of the first two words of the lowest allowed segment is the handshake by which the processor hands control back to the host. The write still lands in host memory, and the bridge also emits a one-clock release pulse.

The sequencer has two states. `ST_IDLE` waits for a data strobe. An accepted strobe to an allowed segment takes the transition *launch* to `ST_BUS`. A strobe to any other segment takes *reject*, which stays in `ST_IDLE` and sets the matching error flag. `ST_BUS` holds the request until the host acknowledges, then takes *complete* back to `ST_IDLE`. A synchronous reset forces `ST_IDLE` from either state.

Top module: `dsp_host_bridge`

## Requirements
- R1: The pointer register changes only when `ptr_load` is high. Data-port accesses leave it as it was, so repeated accesses reach the same host address.
- R2: The host byte address is built from the pointer as follows. Pointer bits 15:13 go to address bits 18:16. Pointer bits 12:0 go to address bits 13:1. Address bits 15:14 and bit 0 are zero.
- R3: A data strobe whose segment is 3, 4 or 5 starts one host cycle. `host_valid`, `host_addr`, `host_we` and `host_wdata` stay steady until the clock edge where `host_ready` is high. `busy` is high for the whole cycle.
- R4: On a host read, `host_rdata` is captured at the acknowledge edge and appears on `dsp_rdata` once `busy` falls.
- R5: A read from any other segment starts no host cycle. It drives `dsp_rdata` to 0x0000 from the next cycle and sets `rd_err`.
- R6: A write to any other segment starts no host cycle and sets `wr_err`.
- R7: `release_pulse` is high for exactly one clock, in the cycle after the acknowledge of a write with all three of these properties: segment 3, pointer word offset 0 or 1 (byte offset below 3), and data 0x0000. The write is still performed on the host bus. Any other write gives no pulse.
- R8: `rd_err` and `wr_err` stay set until `err_clear` is high. If a new error and the clear arrive in the same cycle, the flag ends up set.
- R9: Data strobes that arrive while `busy` is high are ignored. They start no extra host cycle.
- R10: A synchronous active-high `rst` clears the pointer, both error flags, `dsp_rdata` and the release pulse. It also abandons any pending host request, dropping `host_valid` and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Load strobe for the window pointer |
| ptr_word | input | 16 | New pointer value: segment in 15:13, word offset in 12:0 |
| dsp_rd | input | 1 | Data-port read strobe (one cycle) |
| dsp_wr | input | 1 | Data-port write strobe (one cycle) |
| dsp_wdata | input | 16 | Data-port write word |
| dsp_rdata | output | 16 | Last word read, or zero after a rejected read |
| busy | output | 1 | High while a host cycle is outstanding |
| host_valid | output | 1 | Host bus request |
| host_we | output | 1 | Host bus direction, 1 = write |
| host_addr | output | 19 | Host byte address |
| host_wdata | output | 16 | Host write word |
| host_ready | input | 1 | Host acknowledge |
| host_rdata | input | 16 | Host read word, valid with `host_ready` |
| err_clear | input | 1 | Clears both error flags |
| rd_err | output | 1 | Sticky flag for a rejected read |
| wr_err | output | 1 | Sticky flag for a rejected write |
| release_pulse | output | 1 | One-clock host release pulse |

## Verification
The assertions take three things for granted about the inputs. The host raises `host_ready` only while `host_valid` is high. `host_ready` lasts a single cycle per request. The processor never raises both data strobes in the same cycle. The bench's host model follows these rules: it acknowledges once after a chosen delay of zero to twenty cycles and then waits for a fresh request. The processor-side tasks drive one strobe at a time, except in the directed case that deliberately strobes while `busy` is high.

// File: rtl/dhb_pkg.sv
package dhb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } dhb_state_e;
endpackage

// File: rtl/dhb_decode.sv
module dhb_decode #(
    parameter int ADDR_W        = 16,
    parameter int SEG_W         = 3,
    parameter int DATA_W        = 16,
    parameter int HOST_AW       = 19,
    parameter int SEG_FIRST     = 3,
    parameter int SEG_LAST      = 5,
    parameter int EXEC_SEG      = 3,
    parameter int EXEC_BYTE_LIM = 3
) (
    input  logic [ADDR_W-1:0]  ptr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [HOST_AW-1:0] haddr,
    output logic               seg_ok,
    output logic               exec_hit
);
    localparam int OFF_W = ADDR_W - SEG_W;
    localparam logic [SEG_W-1:0] SEG_LO  = SEG_W'(SEG_FIRST);
    localparam logic [SEG_W-1:0] SEG_HI  = SEG_W'(SEG_LAST);
    localparam logic [SEG_W-1:0] SEG_EX  = SEG_W'(EXEC_SEG);
    localparam logic [OFF_W:0]   BYTE_LIM = (OFF_W+1)'(EXEC_BYTE_LIM);

    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [OFF_W:0]   byte_off;

    always_comb begin
        seg      = ptr[ADDR_W-1 -: SEG_W];
        off      = ptr[OFF_W-1:0];
        byte_off = {off, 1'b0};
        haddr    = '0;
        haddr[HOST_AW-1 -: SEG_W] = seg;
        haddr[OFF_W:0]            = byte_off;
        seg_ok   = (seg >= SEG_LO) && (seg <= SEG_HI);
        exec_hit = (seg == SEG_EX) && (byte_off < BYTE_LIM) && (wdata == '0);
    end
endmodule

// File: rtl/dhb_sticky_flags.sv
module dhb_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr)    flag[i] <= 1'b0;
        end

        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flag[i]);
        // R8
        flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (clr && !set[i]) |=> !flag[i]);
    end
endmodule

// File: rtl/dhb_seq.sv
module dhb_seq
    import dhb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int HOST_AW = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  logic               wr_req,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               seg_ok,
    input  logic               exec_hit,
    input  logic [HOST_AW-1:0] req_addr,
    output logic               busy,
    output logic [DATA_W-1:0]  rdata,
    output logic               exec_pulse,
    output logic               rd_rej,
    output logic               wr_rej,
    output logic               host_valid,
    output logic               host_we,
    output logic [HOST_AW-1:0] host_addr,
    output logic [DATA_W-1:0]  host_wdata,
    input  logic               host_ready,
    input  logic [DATA_W-1:0]  host_rdata
);
    dhb_state_e state_q, state_d;
    logic [HOST_AW-1:0] addr_q;
    logic [DATA_W-1:0]  wd_q;
    logic               we_q, exec_q;
    logic               launch, complete;

    always_comb begin
        launch   = (state_q == ST_IDLE) && (rd_req || wr_req) && seg_ok;
        complete = (state_q == ST_BUS) && host_ready;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)   state_d = ST_BUS;
            ST_BUS:  if (complete) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            wd_q       <= '0;
            we_q       <= 1'b0;
            exec_q     <= 1'b0;
            rdata      <= '0;
            exec_pulse <= 1'b0;
        end else begin
            exec_pulse <= complete && we_q && exec_q;
            if (launch) begin
                addr_q <= req_addr;
                wd_q   <= wdata;
                we_q   <= wr_req;
                exec_q <= wr_req && exec_hit;
            end
            if (complete && !we_q) rdata <= host_rdata;
            else if (rd_rej)       rdata <= '0;
        end
    end

    always_comb begin
        busy       = (state_q == ST_BUS);
        host_valid = (state_q == ST_BUS);
        host_we    = we_q;
        host_addr  = addr_q;
        host_wdata = wd_q;
        rd_rej     = (state_q == ST_IDLE) && rd_req && !wr_req && !seg_ok;
        wr_rej     = (state_q == ST_IDLE) && wr_req && !seg_ok;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_ready) |=> (host_valid && $stable(host_addr)
                                         && $stable(host_we) && $stable(host_wdata)));
    // R7
    exec_single_chk: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |=> !exec_pulse);
    // R7
    exec_cause_chk: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |-> $past(host_valid && host_ready && host_we));
    // R5
    rej_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_rej |=> (rdata == '0));
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !host_ready) |=> busy);
endmodule

// File: rtl/dsp_host_bridge.sv
module dsp_host_bridge #(
    parameter int ADDR_W        = 16,
    parameter int SEG_W         = 3,
    parameter int DATA_W        = 16,
    parameter int HOST_AW       = 19,
    parameter int SEG_FIRST     = 3,
    parameter int SEG_LAST      = 5,
    parameter int EXEC_SEG      = 3,
    parameter int EXEC_BYTE_LIM = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ptr_load,
    input  logic [ADDR_W-1:0]  ptr_word,
    input  logic               dsp_rd,
    input  logic               dsp_wr,
    input  logic [DATA_W-1:0]  dsp_wdata,
    output logic [DATA_W-1:0]  dsp_rdata,
    output logic               busy,
    output logic               host_valid,
    output logic               host_we,
    output logic [HOST_AW-1:0] host_addr,
    output logic [DATA_W-1:0]  host_wdata,
    input  logic               host_ready,
    input  logic [DATA_W-1:0]  host_rdata,
    input  logic               err_clear,
    output logic               rd_err,
    output logic               wr_err,
    output logic               release_pulse
);
    localparam logic [SEG_W-1:0] SEG_LO = SEG_W'(SEG_FIRST);
    localparam logic [SEG_W-1:0] SEG_HI = SEG_W'(SEG_LAST);

    logic [ADDR_W-1:0]  ptr_q;
    logic [HOST_AW-1:0] dec_addr;
    logic               seg_ok, exec_hit, rd_rej, wr_rej;
    logic [1:0]         err_flags;

    always_ff @(posedge clk) begin
        if (rst)           ptr_q <= '0;
        else if (ptr_load) ptr_q <= ptr_word;
    end

    dhb_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .DATA_W(DATA_W), .HOST_AW(HOST_AW),
        .SEG_FIRST(SEG_FIRST), .SEG_LAST(SEG_LAST),
        .EXEC_SEG(EXEC_SEG), .EXEC_BYTE_LIM(EXEC_BYTE_LIM)
    ) u_decode (
        .ptr      (ptr_q),
        .wdata    (dsp_wdata),
        .haddr    (dec_addr),
        .seg_ok   (seg_ok),
        .exec_hit (exec_hit)
    );

    dhb_seq #(.DATA_W(DATA_W), .HOST_AW(HOST_AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (dsp_rd),
        .wr_req     (dsp_wr),
        .wdata      (dsp_wdata),
        .seg_ok     (seg_ok),
        .exec_hit   (exec_hit),
        .req_addr   (dec_addr),
        .busy       (busy),
        .rdata      (dsp_rdata),
        .exec_pulse (release_pulse),
        .rd_rej     (rd_rej),
        .wr_rej     (wr_rej),
        .host_valid (host_valid),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata)
    );

    dhb_sticky_flags #(.N(2)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  ({wr_rej, rd_rej}),
        .clr  (err_clear),
        .flag (err_flags)
    );

    assign rd_err = err_flags[0];
    assign wr_err = err_flags[1];

    // R1
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ptr_load |=> $stable(ptr_q));
    // R3
    seg_range_chk: assert property (@(posedge clk) disable iff (rst)
        host_valid |-> (host_addr[HOST_AW-1 -: SEG_W] >= SEG_LO
                        && host_addr[HOST_AW-1 -: SEG_W] <= SEG_HI));
    // R2
    addr_even_chk: assert property (@(posedge clk) disable iff (rst)
        host_valid |-> !host_addr[0]);
endmodule

// File: tb/tb_dsp_host_bridge.sv
module tb_dsp_host_bridge;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, ptr_load = 1'b0, dsp_rd = 1'b0, dsp_wr = 1'b0;
    logic [15:0] ptr_word = '0, dsp_wdata = '0, dsp_rdata;
    logic        busy, host_valid, host_we, host_ready = 1'b0;
    logic [18:0] host_addr;
    logic [15:0] host_wdata, host_rdata = '0;
    logic        err_clear = 1'b0, rd_err, wr_err, release_pulse;

    dsp_host_bridge dut (
        .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_word(ptr_word),
        .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata),
        .dsp_rdata(dsp_rdata), .busy(busy), .host_valid(host_valid),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .err_clear(err_clear), .rd_err(rd_err), .wr_err(wr_err),
        .release_pulse(release_pulse)
    );

    int checks = 0, fails = 0;
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // host memory model: one acknowledge per request after hdelay cycles
    int hdelay = 0, hcnt = 0, nack = 0;
    logic [18:0] s_addr = '0;
    logic        s_we = 1'b0;
    logic [15:0] s_wd = '0;
    always @(negedge clk) begin
        host_ready = 1'b0;
        if (host_valid && !rst) begin
            if (hcnt >= hdelay) begin
                host_ready = 1'b1;
                host_rdata = host_addr[15:0] ^ 16'h5A5A;
                s_addr = host_addr; s_we = host_we; s_wd = host_wdata;
                nack++;
                hcnt = 0;
            end else hcnt++;
        end else hcnt = 0;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic load_ptr(logic [15:0] p);
        @(negedge clk); ptr_load = 1'b1; ptr_word = p;
        @(negedge clk); ptr_load = 1'b0;
    endtask
    task automatic clr_err();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask
    task automatic access(logic is_wr, logic [15:0] wd);
        @(negedge clk); dsp_wr = is_wr; dsp_rd = !is_wr; dsp_wdata = wd;
        @(negedge clk); dsp_wr = 1'b0; dsp_rd = 1'b0;
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    // {is_wr, ptr, wdata, expected host addr, expected release, expected reject}
    localparam int NV = 10;
    localparam logic [53:0] VEC [0:NV-1] = '{
        {1'b0, 16'h6000, 16'h0000, 19'h30000, 1'b0, 1'b0},
        {1'b0, 16'h8005, 16'h0000, 19'h4000A, 1'b0, 1'b0},
        {1'b0, 16'hBFFF, 16'h0000, 19'h53FFE, 1'b0, 1'b0},
        {1'b0, 16'h2001, 16'h0000, 19'h00000, 1'b0, 1'b1},
        {1'b1, 16'h6001, 16'h0000, 19'h30002, 1'b1, 1'b0},
        {1'b1, 16'h6002, 16'h0000, 19'h30004, 1'b0, 1'b0},
        {1'b1, 16'h6000, 16'h0001, 19'h30000, 1'b0, 1'b0},
        {1'b1, 16'h8000, 16'h0000, 19'h40000, 1'b0, 1'b0},
        {1'b1, 16'hE000, 16'h1234, 19'h00000, 1'b0, 1'b1},
        {1'b1, 16'h0000, 16'h0000, 19'h00000, 1'b0, 1'b1}
    };

    initial begin
        int n0;
        logic [15:0] keep;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 host_valid", host_valid, 0);
        chk("R10 rd_err", rd_err, 0);
        chk("R10 wr_err", wr_err, 0);
        chk("R10 rdata", dsp_rdata, 0);
        chk("R10 release", release_pulse, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic        v_wr   = VEC[i][53];
            logic [15:0] v_ptr  = VEC[i][52:37];
            logic [15:0] v_wd   = VEC[i][36:21];
            logic [18:0] v_ha   = VEC[i][20:2];
            logic        v_exec = VEC[i][1];
            logic        v_rej  = VEC[i][0];
            hdelay = i % 3;
            clr_err();
            load_ptr(v_ptr);
            n0 = nack;
            access(v_wr, v_wd);
            if (v_rej) begin
                chk("R5/R6 no host cycle", nack, n0);
                if (v_wr) chk("R6 wr_err", wr_err, 1);
                else begin
                    chk("R5 rd_err", rd_err, 1);
                    chk("R5 zero data", dsp_rdata, 0);
                end
            end else begin
                chk("R3 one host cycle", nack, n0 + 1);
                chk("R2 host addr", s_addr, v_ha);
                chk("R3 direction", s_we, v_wr);
                if (v_wr) chk("R7 write carried out", s_wd, v_wd);
                else      chk("R4 read data", dsp_rdata, v_ha[15:0] ^ 16'h5A5A);
            end
            chk("R7 release", release_pulse, v_exec);
            @(negedge clk);
            chk("R7 release one cycle", release_pulse, 0);
        end

        // R1 pointer held across data accesses
        hdelay = 1;
        load_ptr(16'h8003);
        access(1'b0, 16'h0);
        access(1'b1, 16'h7777);
        access(1'b0, 16'h0);
        chk("R1 same address", s_addr, 19'h40006);

        // R8 sticky flags
        clr_err();
        load_ptr(16'h4000);
        access(1'b0, 16'h0);
        load_ptr(16'h6010);
        access(1'b0, 16'h0);
        chk("R8 rd_err sticky", rd_err, 1);
        clr_err();
        chk("R8 cleared", rd_err, 0);
        load_ptr(16'hC000);
        @(negedge clk); dsp_wr = 1'b1; err_clear = 1'b1;
        @(negedge clk); dsp_wr = 1'b0; err_clear = 1'b0;
        chk("R8 set beats clear", wr_err, 1);

        // R9 strobes while busy ignored
        hdelay = 5;
        load_ptr(16'hA000);
        keep = dsp_rdata;
        n0 = nack;
        @(negedge clk); dsp_wr = 1'b1; dsp_wdata = 16'h00AA;
        @(negedge clk); dsp_wr = 1'b0;
        @(negedge clk); dsp_rd = 1'b1;
        @(negedge clk); dsp_rd = 1'b0;
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 one host cycle", nack, n0 + 1);
        chk("R9 was write", s_we, 1);
        chk("R9 rdata untouched", dsp_rdata, keep);

        // R10 reset abandons request and clears pointer
        hdelay = 20;
        n0 = nack;
        @(negedge clk); dsp_rd = 1'b1;
        @(negedge clk); dsp_rd = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 busy dropped", busy, 0);
        chk("R10 valid dropped", host_valid, 0);
        chk("R10 no acknowledge", nack, n0);
        access(1'b0, 16'h0);
        chk("R10 pointer cleared", rd_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule